// File: doc/BRIEF.md
# Line-Bit Interframe Gap Meter

This block sits on the receive side of a 10 Gb/s link after block alignment and descrambling. It looks at one 66-bit block per valid cycle. Only the 2-bit block header and the first payload byte, which is the block type for control blocks, enter the block. Every block adds 66 to a free-running line-bit clock. At one bit per symbol and 10.3125 Gbaud, one count is about 97 ps, so the count works directly as a sub-nanosecond timestamp.

Frame starts and ends are found from the type of control blocks. Their exact line-bit positions come from the character layout inside the block, with control characters 7 bits wide and data octets 8 bits wide. Because of this, gaps are resolved to single bits and need not be multiples of eight.

For each finished frame the block produces one record. The record holds the line-bit position of the frame start, the gap since the end of the previous frame, and the frame span. It also carries a flag for a gap shorter than the legal minimum. A record is held until a consumer takes it.

Top module: `ifgm_gap_meter`

## Requirements
- R1: Each cycle with `in_valid` high advances the line-bit clock by 66. The clock starts at 0 after reset. Cycles with `in_valid` low do not advance it.
- R2: A block with header 2'b10 and type 8'h78 starts a frame at bit offset 10 of that block. Type 8'h33 starts a frame at bit offset 42. The record timestamp is 66 times the number of valid blocks before the start block, plus that offset.
- R3: A block with header 2'b10 and type 8'h87, 8'h99, 8'hAA, 8'hB4, 8'hCC, 8'hD2, 8'hE1 or 8'hFF ends an open frame. These types mean terminate lane k = 0 to 7 in that order. The frame end lies at bit offset 10+8k of that block. The record length is the end position minus the start position.
- R4: The record gap is the start position of the frame minus the end position of the previous frame. For the first frame after reset, `out_gap_valid` is 0 and `out_gap` is 0.
- R5: `out_short_gap` is 1 exactly when the gap is valid and below MIN_GAP_BITS (default 96). A gap of 90 bits sets it. A gap of 98 bits does not.
- R6: A record appears on the outputs at the clock edge that takes its ending block. It stays unchanged while `out_valid` is high and `out_ready` is low. It is removed at an edge where both are high.
- R7: If a frame ends while a record is still held, the new record is dropped. `out_overflow` goes to 1 and stays there until the held record is taken. The end of the dropped frame still serves as the reference for the next gap.
- R8: Data blocks, control blocks of other types, and ending blocks that arrive with no frame open produce no record. They also do not move the gap reference.
- R9: After reset, `out_valid` and `out_overflow` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A block is present this cycle |
| in_sync | input | 2 | Block header, 2'b10 marks a control block |
| in_type | input | 8 | First payload byte (block type for control blocks) |
| out_ready | input | 1 | Consumer takes the held record |
| out_valid | output | 1 | A record is held |
| out_ts | output | 48 | Line-bit position of the frame start |
| out_gap | output | 32 | Gap before the frame, in line bits |
| out_len | output | 32 | Frame span, in line bits |
| out_gap_valid | output | 1 | Gap has a previous frame end to refer to |
| out_short_gap | output | 1 | Valid gap below the legal minimum |
| out_overflow | output | 1 | A later record was dropped while this one was held |

## Verification
Frames are sent with both start positions (offsets 10 and 42) and with ending lanes 0, 1, 4 and 7. A wrong character width or lane offset therefore shows up as a distinct timestamp, length or gap error. Idle cycles with `in_valid` low are placed inside frames to separate counting by cycle from counting by block.

Back-to-back pairs give gaps of 10, 90 and 98 bits. These fall on both sides of the 96-bit limit and tell apart a correct minimum test from a byte-rounded or off-by-one one.

A stalled consumer with two frames finishing shows the difference between dropping and overwriting a record, and checks that the dropped frame still serves as the gap reference. A stray ending block with no frame open shows whether the gap reference is disturbed.

// File: rtl/ifgm_pkg.sv
package ifgm_pkg;
    localparam int SYNC_BITS  = 2;
    localparam int TYPE_BITS  = 8;
    localparam int OCTET_BITS = 8;
    localparam int CHAR_BITS  = 7;
    localparam int LANES      = 8;
    localparam int BLOCK_BITS = SYNC_BITS + OCTET_BITS * LANES;
    localparam int TS_W       = 48;
    localparam int CNT_W      = 32;
    localparam int OFF_W      = $clog2(BLOCK_BITS + 1);

    localparam logic [1:0] HDR_CTRL = 2'b10;
    localparam logic [7:0] TYPE_SOF_L0 = 8'h78;
    localparam logic [7:0] TYPE_SOF_L4 = 8'h33;

    // start positions inside a block, in line bits
    localparam int SOF_OFF_L0 = SYNC_BITS + TYPE_BITS;
    localparam int SOF_OFF_L4 = SYNC_BITS + TYPE_BITS + 4 * CHAR_BITS + 4;

    // terminate types, indexed by the lane holding the terminate
    localparam logic [7:0] TERM_TYPE [LANES] = '{
        8'h87, 8'h99, 8'hAA, 8'hB4, 8'hCC, 8'hD2, 8'hE1, 8'hFF
    };

    typedef struct packed {
        logic [TS_W-1:0]  ts;
        logic [CNT_W-1:0] gap;
        logic [CNT_W-1:0] len;
        logic             gap_ok;
        logic             short_gap;
    } rec_t;
endpackage

// File: rtl/ifgm_block_decode.sv
module ifgm_block_decode
    import ifgm_pkg::*;
(
    input  logic             valid,
    input  logic [1:0]       sync,
    input  logic [7:0]       btype,
    output logic             is_start,
    output logic             is_term,
    output logic [OFF_W-1:0] start_off,
    output logic [OFF_W-1:0] end_off
);
    logic is_ctrl;
    logic [LANES-1:0] lane_hit;

    assign is_ctrl = valid && (sync == HDR_CTRL);

    genvar k;
    generate
        for (k = 0; k < LANES; k++) begin : g_lane
            assign lane_hit[k] = is_ctrl && (btype == TERM_TYPE[k]);
        end
    endgenerate

    always_comb begin
        is_start  = 1'b0;
        start_off = '0;
        if (is_ctrl && btype == TYPE_SOF_L0) begin
            is_start  = 1'b1;
            start_off = OFF_W'(SOF_OFF_L0);
        end else if (is_ctrl && btype == TYPE_SOF_L4) begin
            is_start  = 1'b1;
            start_off = OFF_W'(SOF_OFF_L4);
        end
    end

    always_comb begin
        is_term = |lane_hit;
        end_off = '0;
        for (int i = 0; i < LANES; i++) begin
            if (lane_hit[i]) begin
                end_off = OFF_W'(SYNC_BITS + TYPE_BITS + OCTET_BITS * i);
            end
        end
    end

    always_comb begin
        assert (!(is_start && is_term)) else $error("p_one_event_r8: start and end in one block");
    end
endmodule

// File: rtl/ifgm_line_clock.sv
module ifgm_line_clock
    import ifgm_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            valid,
    output logic [TS_W-1:0] base
);
    typedef struct packed {
        logic [TS_W-1:0] cnt;
    } clk_state_t;

    clk_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (valid) begin
            st_d.cnt = st_q.cnt + TS_W'(BLOCK_BITS);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign base = st_q.cnt;

    p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |=> $stable(base));
endmodule

// File: rtl/ifgm_frame_track.sv
module ifgm_frame_track
    import ifgm_pkg::*;
#(
    parameter int MIN_GAP_BITS = 96
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TS_W-1:0]  base,
    input  logic             is_start,
    input  logic             is_term,
    input  logic [OFF_W-1:0] start_off,
    input  logic [OFF_W-1:0] end_off,
    output logic             rec_fire,
    output rec_t             rec
);
    typedef struct packed {
        logic            in_frame;
        logic            have_end;
        logic [TS_W-1:0] start_abs;
        logic [TS_W-1:0] end_abs;
    } trk_state_t;

    trk_state_t st_d, st_q;
    logic [TS_W-1:0] pos_start, pos_end, gap_full, len_full;

    always_comb begin
        st_d      = st_q;
        rec_fire  = 1'b0;
        rec       = '0;
        pos_start = base + TS_W'(start_off);
        pos_end   = base + TS_W'(end_off);
        gap_full  = st_q.start_abs - st_q.end_abs;
        len_full  = pos_end - st_q.start_abs;
        if (is_term && st_q.in_frame) begin
            rec_fire      = 1'b1;
            rec.ts        = st_q.start_abs;
            rec.len       = len_full[CNT_W-1:0];
            rec.gap_ok    = st_q.have_end;
            rec.gap       = st_q.have_end ? gap_full[CNT_W-1:0] : '0;
            rec.short_gap = st_q.have_end && (gap_full < TS_W'(MIN_GAP_BITS));
            st_d.in_frame = 1'b0;
            st_d.have_end = 1'b1;
            st_d.end_abs  = pos_end;
        end
        if (is_start) begin
            st_d.in_frame  = 1'b1;
            st_d.start_abs = pos_start;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    p_len_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rec_fire |-> rec.len != '0);
    p_gap_after_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rec_fire && rec.gap_ok |-> rec.ts > st_q.end_abs);
endmodule

// File: rtl/ifgm_record_hold.sv
module ifgm_record_hold
    import ifgm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rec_fire,
    input  rec_t rec_in,
    input  logic out_ready,
    output logic out_valid,
    output logic out_overflow,
    output rec_t out_rec
);
    typedef struct packed {
        logic valid;
        logic ovf;
        rec_t rec;
    } hold_state_t;

    hold_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.valid && out_ready) begin
            st_d.valid = 1'b0;
            st_d.ovf   = 1'b0;
        end
        if (rec_fire) begin
            if (st_d.valid) begin
                st_d.ovf = 1'b1;
            end else begin
                st_d.valid = 1'b1;
                st_d.ovf   = 1'b0;
                st_d.rec   = rec_in;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid    = st_q.valid;
    assign out_overflow = st_q.ovf;
    assign out_rec      = st_q.rec;

    p_hold_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_rec));
    p_ovf_needs_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_overflow |-> out_valid);
    p_ovf_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready |=> !out_overflow);
endmodule

// File: rtl/ifgm_gap_meter.sv
module ifgm_gap_meter
    import ifgm_pkg::*;
#(
    parameter int MIN_GAP_BITS = 96
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [1:0]        in_sync,
    input  logic [7:0]        in_type,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [TS_W-1:0]   out_ts,
    output logic [CNT_W-1:0]  out_gap,
    output logic [CNT_W-1:0]  out_len,
    output logic              out_gap_valid,
    output logic              out_short_gap,
    output logic              out_overflow
);
    logic             is_start, is_term, rec_fire;
    logic [OFF_W-1:0] start_off, end_off;
    logic [TS_W-1:0]  base;
    rec_t             rec, held;

    ifgm_block_decode u_dec (
        .valid(in_valid), .sync(in_sync), .btype(in_type),
        .is_start(is_start), .is_term(is_term),
        .start_off(start_off), .end_off(end_off)
    );

    ifgm_line_clock u_clk (
        .clk(clk), .rst_n(rst_n), .valid(in_valid), .base(base)
    );

    ifgm_frame_track #(.MIN_GAP_BITS(MIN_GAP_BITS)) u_trk (
        .clk(clk), .rst_n(rst_n), .base(base),
        .is_start(is_start), .is_term(is_term),
        .start_off(start_off), .end_off(end_off),
        .rec_fire(rec_fire), .rec(rec)
    );

    ifgm_record_hold u_hold (
        .clk(clk), .rst_n(rst_n), .rec_fire(rec_fire), .rec_in(rec),
        .out_ready(out_ready), .out_valid(out_valid),
        .out_overflow(out_overflow), .out_rec(held)
    );

    assign out_ts        = held.ts;
    assign out_gap       = held.gap;
    assign out_len       = held.len;
    assign out_gap_valid = held.gap_ok;
    assign out_short_gap = held.short_gap;

    p_short_is_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_short_gap |-> out_gap_valid && out_gap < CNT_W'(MIN_GAP_BITS));
endmodule

// File: tb/ifgm_gap_meter_bench.sv
module ifgm_gap_meter_bench;
    logic clk = 1'b0, rst_n = 1'b0;
    logic in_valid = 1'b0, out_ready = 1'b0;
    logic [1:0] in_sync = 2'b01;
    logic [7:0] in_type = 8'h00;
    logic out_valid, out_gap_valid, out_short_gap, out_overflow;
    logic [47:0] out_ts;
    logic [31:0] out_gap, out_len;

    int n_chk = 0, n_fail = 0;
    longint nblk = 0;
    bit m_open = 0, m_have = 0;
    longint m_start = 0, m_end = 0;
    longint e_ts, e_gap, e_len;
    bit e_gok, e_short;

    always #4 clk = ~clk;

    ifgm_gap_meter u_ifgm_gap_meter (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sync(in_sync),
        .in_type(in_type), .out_ready(out_ready), .out_valid(out_valid),
        .out_ts(out_ts), .out_gap(out_gap), .out_len(out_len),
        .out_gap_valid(out_gap_valid), .out_short_gap(out_short_gap),
        .out_overflow(out_overflow)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int term_lane(input logic [7:0] t);
        case (t)
            8'h87: return 0; 8'h99: return 1; 8'hAA: return 2; 8'hB4: return 3;
            8'hCC: return 4; 8'hD2: return 5; 8'hE1: return 6; 8'hFF: return 7;
            default: return -1;
        endcase
    endfunction

    // one block; bench model follows R1-style counting, offsets of R2 and R3
    task automatic blk(input logic [1:0] s, input logic [7:0] t);
        int lane;
        @(negedge clk);
        in_valid = 1'b1; in_sync = s; in_type = t; out_ready = 1'b0;
        lane = term_lane(t);
        if (s == 2'b10 && lane >= 0 && m_open) begin
            longint pe = nblk * 66 + 10 + 8 * lane;
            e_ts = m_start; e_len = pe - m_start; e_gok = m_have;
            e_gap = m_have ? m_start - m_end : 0;
            e_short = m_have && (e_gap < 96);
            m_open = 0; m_have = 1; m_end = pe;
        end else if (s == 2'b10 && (t == 8'h78 || t == 8'h33)) begin
            m_open = 1; m_start = nblk * 66 + ((t == 8'h78) ? 10 : 42);
        end
        nblk++;
    endtask

    task automatic idle_blk(); blk(2'b10, 8'h1E); endtask
    task automatic data_blk(); blk(2'b01, 8'h5A); endtask

    task automatic bubble();
        @(negedge clk);
        in_valid = 1'b0; out_ready = 1'b0;
    endtask

    task automatic pop();
        @(negedge clk);
        in_valid = 1'b0; out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
    endtask

    task automatic check_rec(input string req);
        chk(out_valid == 1'b1, req, "out_valid", out_valid, 1);
        chk(out_ts == e_ts, req, "timestamp", out_ts, e_ts);
        chk(out_len == e_len, req, "length", out_len, e_len);
        chk(out_gap == e_gap, req, "gap", out_gap, e_gap);
        chk(out_gap_valid == e_gok, req, "gap_valid", out_gap_valid, e_gok);
        chk(out_short_gap == e_short, req, "short_gap", out_short_gap, e_short);
    endtask

    task automatic t_reset();
        chk(out_valid == 0, "R9", "out_valid after reset", out_valid, 0);
        chk(out_overflow == 0, "R9", "overflow after reset", out_overflow, 0);
    endtask

    task automatic t_first_frame();   // R2 lane0 start, R3 lane 4, R4 first gap
        idle_blk(); idle_blk();
        blk(2'b10, 8'h78); data_blk(); data_blk(); data_blk();
        blk(2'b10, 8'hCC);
        bubble();
        check_rec("R2/R3/R4 first");
        chk(out_gap_valid == 0, "R4", "first gap flagged", out_gap_valid, 0);
        pop();
        chk(out_valid == 0, "R6", "taken record removed", out_valid, 0);
    endtask

    task automatic t_lane4_with_holes();   // R1 holes do not count, R2 offset 42
        idle_blk(); idle_blk(); idle_blk();
        blk(2'b10, 8'h33); bubble(); data_blk(); bubble(); bubble(); data_blk();
        blk(2'b10, 8'h87);
        bubble();
        check_rec("R1/R2 lane4");
        pop();
    endtask

    task automatic t_short_gaps();   // R5 around the 96-bit limit
        blk(2'b10, 8'h78); data_blk(); blk(2'b10, 8'hFF); pop();
        blk(2'b10, 8'h78); data_blk(); blk(2'b10, 8'h87); bubble();
        check_rec("R5 gap10");
        chk(out_short_gap == 1 && e_gap == 10, "R5", "gap 10 short", out_short_gap, 1);
        pop();
        blk(2'b10, 8'h33); data_blk(); blk(2'b10, 8'h99); bubble();
        check_rec("R5 gap98");
        chk(out_short_gap == 0 && e_gap == 98, "R5", "gap 98 not short", out_short_gap, 0);
        pop();
        blk(2'b10, 8'h33); data_blk(); blk(2'b10, 8'h87); bubble();
        check_rec("R5 gap90");
        chk(out_short_gap == 1 && e_gap == 90, "R5", "gap 90 short", out_short_gap, 1);
        pop();
    endtask

    task automatic t_hold();   // R6
        longint ts0;
        idle_blk(); blk(2'b10, 8'h78); data_blk(); blk(2'b10, 8'hB4); bubble();
        ts0 = e_ts;
        for (int i = 0; i < 4; i++) begin
            idle_blk();
            chk(out_valid == 1 && out_ts == ts0, "R6", "held record", out_ts, ts0);
        end
        bubble();
        check_rec("R6 held");
        pop();
        chk(out_valid == 0, "R6", "cleared after take", out_valid, 0);
    endtask

    task automatic t_overflow();   // R7
        longint a_ts, a_len;
        blk(2'b10, 8'h78); data_blk(); blk(2'b10, 8'hD2); bubble();
        a_ts = e_ts; a_len = e_len;
        chk(out_overflow == 0, "R7", "no overflow yet", out_overflow, 0);
        idle_blk(); blk(2'b10, 8'h33); data_blk(); blk(2'b10, 8'hE1); bubble();
        chk(out_overflow == 1, "R7", "overflow set", out_overflow, 1);
        chk(out_ts == a_ts, "R7", "first record kept ts", out_ts, a_ts);
        chk(out_len == a_len, "R7", "first record kept len", out_len, a_len);
        pop();
        chk(out_overflow == 0, "R7", "overflow cleared", out_overflow, 0);
        chk(out_valid == 0, "R7", "no stale record", out_valid, 0);
        idle_blk(); idle_blk(); blk(2'b10, 8'h78); data_blk(); blk(2'b10, 8'hAA); bubble();
        check_rec("R7 gap from dropped frame");
        pop();
    endtask

    task automatic t_ignored();   // R8
        blk(2'b10, 8'hCC); idle_blk(); data_blk(); blk(2'b10, 8'h4B); blk(2'b10, 8'hFF);
        bubble(); bubble();
        chk(out_valid == 0, "R8", "no record without open frame", out_valid, 0);
        idle_blk(); blk(2'b10, 8'h78); data_blk(); blk(2'b10, 8'h87); bubble();
        check_rec("R8 reference unmoved");
        pop();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_first_frame();
        t_lane4_with_holes();
        t_short_gaps();
        t_hold();
        t_overflow();
        t_ignored();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule